// File: doc/BRIEF.md
# Receive Destination Filter

This block takes the first word of each incoming frame and decides whether the rest of the frame is wanted. The destination host byte sits in the top eight bits of that word. Two ways of filtering are available, and the configured host register picks between them. When its sign bit is clear, the filter compares the destination with one station address. It also lets broadcast frames through, and it passes everything when the station address is zero. When the sign bit is set, the destination indexes a 256-bit acceptance map. The map is kept as sixteen 16-bit words in a small local memory that software loads through its own write port.

The first word arrives on a valid/ready stream. The filter holds one header at a time. `hdr_ready` drops for the cycle after a handshake, and a source facing a low `hdr_ready` must hold `hdr_word` and `desc_avail` steady with `hdr_valid` high. A one-cycle `dec_valid` pulse carries the verdict in `dec_accept`. A rejected frame also raises `skip_req`, which tells the receiver to discard the remainder and wait for the next start of frame. If no receive descriptor was free when the header was taken, the frame is dropped whatever the filter says, and a 16-bit missed-frame count goes up by one.

Top module: `rx_dest_filter`

## Requirements
- R1: The destination is `hdr_word[15:8]`; bits 7:0 of the header word never change the verdict.
- R2: `host_cfg` is sampled at the handshake. With `host_cfg[15]` = 1 the map decides; with `host_cfg[15]` = 0 the single-address compare decides. For example, `host_cfg` = 16'h8000 selects the map.
- R3: In address-compare mode a frame is accepted when its destination is 0 (broadcast) or when `{8'h00, dest}` equals `host_cfg`; any other destination is rejected.
- R4: In address-compare mode, `host_cfg` = 0 accepts every destination.
- R5: In map mode the verdict is map word `dest[7:4]`, bit `15 - dest[3:0]`. Bit index 0 within a word is therefore the word's most significant bit.
- R6: A rejected frame raises `skip_req` in the same cycle as `dec_valid`, with `dec_accept` = 0. An accepted frame leaves `skip_req` low.
- R7: When `desc_avail` is low at the handshake, the frame is rejected (with `skip_req`) whatever the filter says, and `missed_count` goes up by one, wrapping at 16 bits. `missed_count` changes at no other time.
- R8: For a handshake on rising edge N, `dec_valid` is high only for the cycle after edge N+1.
- R9: `hdr_ready` is low for the cycle after a handshake and high otherwise.
- R10: A map write (`map_wr_en`, `map_wr_addr`, `map_wr_data`) made in the same cycle as a handshake does not affect that frame. It does decide the next frame.
- R11: After reset, `dec_valid`, `dec_accept`, `skip_req` and `missed_count` are 0, `hdr_ready` is 1, and every map bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | First frame word is present |
| hdr_ready | output | 1 | Filter can take a header |
| hdr_word | input | 16 | First frame word; destination in bits 15:8 |
| desc_avail | input | 1 | A receive descriptor is free for this frame |
| host_cfg | input | 16 | Station address, or negative to select map mode |
| map_wr_en | input | 1 | Write strobe for the acceptance map |
| map_wr_addr | input | 4 | Map word index |
| map_wr_data | input | 16 | Map word, bit 15 = lowest destination of the group |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame accepted |
| skip_req | output | 1 | Discard the rest of this frame |
| missed_count | output | 16 | Frames dropped for lack of a descriptor |

## Verification
The hardest case to reach from the ports is a map update landing in the very cycle a header is taken. The frame must then see the old map bit while the next frame sees the new one. The bench drives a directed write in the same cycle as a handshake, flipping the exact bit that the header selects. It then sends the same header again. It also mixes random map writes and random headers across both modes, with a few descriptor-less frames, so that the two ends of each map word (bit 15 and bit 0) and the sign-bit boundary of `host_cfg` are all exercised.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int unsigned FILT_WORD_W = 16;
  localparam int unsigned FILT_DEST_W = 8;
  localparam int unsigned FILT_CNT_W  = 16;

  typedef enum logic [0:0] {
    MODE_COMPARE = 1'b0,
    MODE_MAP     = 1'b1
  } filt_mode_e;
endpackage

// File: rtl/accept_map_ram.sv
module accept_map_ram #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Read returns the contents before any same-cycle write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= mem[rd_addr];
      if (wr_en) mem[wr_addr] <= wr_data;
    end
  end

  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/addr_compare.sv
module addr_compare #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEST_W = 8
) (
  input  logic [DEST_W-1:0] dest,
  input  logic [WORD_W-1:0] station,
  output logic              hit
);
  logic is_bcast, is_promisc, is_self;

  always_comb begin
    is_bcast   = (dest == '0);
    is_promisc = (station == '0);
    is_self    = ({{(WORD_W-DEST_W){1'b0}}, dest} == station);
    hit        = is_bcast || is_promisc || is_self;
  end
endmodule

// File: rtl/miss_counter.sv
module miss_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= count + 1'b1;
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_filt_pkg::*;
#(
  parameter int unsigned WORD_W = FILT_WORD_W,
  parameter int unsigned DEST_W = FILT_DEST_W,
  parameter int unsigned CNT_W  = FILT_CNT_W,
  localparam int unsigned MAP_DEPTH = (1 << DEST_W) / WORD_W,
  localparam int unsigned IDX_W     = $clog2(WORD_W),
  localparam int unsigned ADDR_W    = DEST_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [WORD_W-1:0] hdr_word,
  input  logic              desc_avail,
  input  logic [WORD_W-1:0] host_cfg,
  input  logic              map_wr_en,
  input  logic [ADDR_W-1:0] map_wr_addr,
  input  logic [WORD_W-1:0] map_wr_data,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              skip_req,
  output logic [CNT_W-1:0]  missed_count
);
  logic              take;
  logic [DEST_W-1:0] hdr_dest;
  logic              s1_vld;
  logic [DEST_W-1:0] s1_dest;
  logic [WORD_W-1:0] s1_host;
  logic              s1_desc;
  logic [WORD_W-1:0] map_word;
  logic              cmp_hit;
  logic [IDX_W-1:0]  bit_sel;
  filt_mode_e        mode;
  logic              filt_hit;
  logic              pass;
  logic              drop_bump;
  logic [WORD_W-DEST_W-1:0] unused_low;

  assign take       = hdr_valid && hdr_ready;
  assign hdr_ready  = !s1_vld;
  assign hdr_dest   = hdr_word[WORD_W-1 -: DEST_W];
  assign unused_low = hdr_word[WORD_W-DEST_W-1:0];

  // Stage 1: capture header, mode and descriptor state; start map read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_dest <= '0;
      s1_host <= '0;
      s1_desc <= 1'b0;
    end else begin
      s1_vld <= take;
      if (take) begin
        s1_dest <= hdr_dest;
        s1_host <= host_cfg;
        s1_desc <= desc_avail;
      end
    end
  end

  accept_map_ram #(.WORD_W(WORD_W), .DEPTH(MAP_DEPTH)) map_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr_en),
    .wr_addr (map_wr_addr),
    .wr_data (map_wr_data),
    .rd_en   (take),
    .rd_addr (hdr_dest[DEST_W-1 -: ADDR_W]),
    .rd_data (map_word)
  );

  addr_compare #(.WORD_W(WORD_W), .DEST_W(DEST_W)) cmp_i (
    .dest    (s1_dest),
    .station (s1_host),
    .hit     (cmp_hit)
  );

  // Stage 2: pick the verdict; the map bit is left-justified.
  always_comb begin
    mode     = filt_mode_e'(s1_host[WORD_W-1]);
    bit_sel  = IDX_W'(WORD_W-1) - s1_dest[IDX_W-1:0];
    filt_hit = (mode == MODE_MAP) ? map_word[bit_sel] : cmp_hit;
    pass     = s1_desc && filt_hit;
  end

  assign drop_bump = s1_vld && !s1_desc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      skip_req   <= 1'b0;
    end else begin
      dec_valid  <= s1_vld;
      dec_accept <= s1_vld && pass;
      skip_req   <= s1_vld && !pass;
    end
  end

  miss_counter #(.CNT_W(CNT_W)) miss_i (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (drop_bump),
    .count (missed_count)
  );

  a_r8_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ##2 dec_valid);
  a_r9_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !hdr_ready);
  a_r6_skip_excludes_accept: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> dec_valid && !dec_accept);
  a_r7_miss_only_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_count != $past(missed_count)) |-> skip_req);
endmodule

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hdr_valid;
  logic        hdr_ready;
  logic [15:0] hdr_word;
  logic        desc_avail;
  logic [15:0] host_cfg;
  logic        map_wr_en;
  logic [3:0]  map_wr_addr;
  logic [15:0] map_wr_data;
  logic        dec_valid;
  logic        dec_accept;
  logic        skip_req;
  logic [15:0] missed_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [15:0] model_map [16];
  logic [15:0] exp_missed;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_word(hdr_word), .desc_avail(desc_avail), .host_cfg(host_cfg),
    .map_wr_en(map_wr_en), .map_wr_addr(map_wr_addr), .map_wr_data(map_wr_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .skip_req(skip_req),
    .missed_count(missed_count)
  );

  function automatic bit want(input logic [7:0] dest, input logic [15:0] host,
                              input bit desc);
    bit h;
    if (host[15]) h = model_map[dest[7:4]][15 - dest[3:0]];
    else          h = (dest == 8'h00) || (host == 16'h0000) || ({8'h00, dest} == host);
    return desc && h;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic map_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    map_wr_en = 1'b1; map_wr_addr = a; map_wr_data = d;
    @(negedge clk);
    map_wr_en = 1'b0;
    model_map[a] = d;
  endtask

  // Sends one header; optionally writes the map in the handshake cycle.
  task automatic frame(input logic [15:0] w, input bit desc, input string req,
                       input bit wr = 0, input logic [3:0] wa = 0,
                       input logic [15:0] wd = 0);
    bit e;
    @(negedge clk);
    e = want(w[15:8], host_cfg, desc);
    hdr_valid = 1'b1; hdr_word = w; desc_avail = desc;
    if (wr) begin map_wr_en = 1'b1; map_wr_addr = wa; map_wr_data = wd; end
    @(posedge clk); #1;
    chk(hdr_ready == 1'b0, "R9", hdr_ready, 0);
    chk(dec_valid == 1'b0, "R8", dec_valid, 0);
    @(negedge clk);
    hdr_valid = 1'b0; hdr_word = 16'($urandom); desc_avail = $urandom;
    map_wr_en = 1'b0;
    if (wr) model_map[wa] = wd;
    if (!desc) exp_missed = exp_missed + 16'd1;
    @(posedge clk); #1;
    chk(dec_valid == 1'b1, "R8", dec_valid, 1);
    chk(dec_accept == e, req, dec_accept, e);
    chk(skip_req == !e, "R6", skip_req, !e);
    chk(missed_count == exp_missed, "R7", missed_count, exp_missed);
    @(posedge clk); #1;
    chk(dec_valid == 1'b0, "R8", dec_valid, 0);
    chk(hdr_ready == 1'b1, "R9", hdr_ready, 1);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; hdr_valid = 1'b0; hdr_word = '0; desc_avail = 1'b1;
    host_cfg = 16'h0042; map_wr_en = 1'b0; map_wr_addr = '0; map_wr_data = '0;
    exp_missed = '0;
    for (int i = 0; i < 16; i++) model_map[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(dec_valid == 0 && dec_accept == 0 && skip_req == 0, "R11", dec_valid, 0);
    chk(missed_count == 0, "R11", missed_count, 0);
    chk(hdr_ready == 1, "R11", hdr_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // R3: broadcast, own address, other address; low byte ignored (R1)
    frame(16'h00A5, 1, "R3");
    frame(16'h42FF, 1, "R3");
    frame(16'h4342, 1, "R3");
    frame(16'h4200, 1, "R1");
    // R4: promiscuous
    host_cfg = 16'h0000;
    frame(16'h9C11, 1, "R4");
    // R3: host above 255 never matches a non-zero destination
    host_cfg = 16'h0142;
    frame(16'h4200, 1, "R3");
    // R11 map cleared, R2 sign bit selects map
    host_cfg = 16'h8000;
    frame(16'h0000, 1, "R11");
    frame(16'h4200, 1, "R2");
    // R5: MSB = index 0, LSB = index 15
    map_write(4'h0, 16'h8000);
    map_write(4'hF, 16'h0001);
    frame(16'h0000, 1, "R5");
    frame(16'h0100, 1, "R5");
    frame(16'hFF00, 1, "R5");
    frame(16'hFE00, 1, "R5");
    // R7: no descriptor overrides an accepting filter
    frame(16'h0000, 0, "R7");
    host_cfg = 16'h0000;
    frame(16'h1234, 0, "R7");
    // R10: same-cycle write is not seen, next frame sees it
    host_cfg = 16'hFFFF;
    frame(16'h5300, 1, "R10", 1, 4'h5, 16'h1000);
    frame(16'h5300, 1, "R10");
    frame(16'h5300, 1, "R10", 1, 4'h5, 16'h0000);
    frame(16'h5300, 1, "R10");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      if (r < 2) map_write(4'($urandom), 16'($urandom));
      if (r == 3) host_cfg = 16'($urandom);
      else if (r == 4) host_cfg = {8'h00, 8'($urandom)};
      else if (r == 5) host_cfg = 16'h0000;
      frame(16'($urandom), ($urandom_range(0, 7) != 0), host_cfg[15] ? "R5" : "R3",
            ($urandom_range(0, 5) == 0), 4'($urandom), 16'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule